// File: doc/BRIEF.md
# Indexed Gather/Scatter Address Generator

This block turns one command and one or two streams of 32-bit indices into a stream of source/destination address pairs for a downstream memory mover. A 2-bit mode decides which side is steered by indices: the source side (gather), the destination side (scatter), or both sides, each with its own independent index stream. A side that is not indexed walks forward by a fixed step from its start address. Every pair leaves the block with the command's reduce opcode, which the mover uses to combine data at the destination.

Every index on an indexed side can be checked against an upper bound taken from a bank of bound registers. An index that fails the check is consumed, but no pair is produced for it. The command decides whether such an index also raises an error pulse. When the command does not permit repeated destinations, a small seen-set records destination indices that have already been sent. An index that hits the set is dropped and flagged.

Back-pressure rules: the index streams and the address output use valid/ready. An index is consumed on a cycle where its valid and ready are both high. Ready may depend on valid, because an element is consumed only when every index it needs is present on that cycle. A pair that is presented with out_valid high holds stable until out_ready is high. Command, status and error pins are plain signals.

Top module: `indirect_addr_gen`

## Requirements
- R1: cmd_mode 0 indexes the source side only and strides the destination side. Mode 1 indexes the destination side only and strides the source side. Mode 2 indexes both sides. Mode 3 is reserved and the command is rejected.
- R2: On an indexed side, the address is the start address plus the index times that side's element size in bytes, computed modulo 2^64.
- R3: On a strided side, the address of element k is the start address plus k times the step times the element size. k counts every element of the command, including dropped ones.
- R4: A command with cmd_count above 4096, or with mode 3, gives a one-cycle cmd_reject pulse on the cycle after cmd_start. It produces no pairs, consumes no indices and gives no done pulse. A count of exactly 4096 is accepted.
- R5: A check byte is {enable bit 7, quiet bit 6, register select bits 5:0}. When enable is set, an index is out of bounds if it is greater than or equal to bound register `sel`, which sits in bound_regs bits [32*sel+31 : 32*sel]. When enable is clear, there is no check.
- R6: An element with an out-of-bounds index on either side is consumed from its index streams but produces no output pair.
- R7: err_bound pulses for one cycle, on the cycle after the element is consumed, when that element is out of bounds on a side whose quiet bit is clear and cmd_bound_err is set. In all other cases no error is raised.
- R8: Each output pair carries cmd_reduce unchanged on out_reduce (0 copy, 1 add, 2 multiply, 3 max, 4 min).
- R9: If cmd_allow_dup is clear and the destination is indexed, an in-bounds destination index equal to one already recorded in this command is dropped, and err_dup pulses on the next cycle. The set records the destination index of each emitted pair, up to DUP_DEPTH (16) entries, and is emptied at each command start. If cmd_allow_dup is set, repeated indices are emitted normally.
- R10: While out_valid is high and out_ready is low, out_valid, out_src_addr, out_dst_addr and out_reduce hold their values.
- R11: done pulses for one cycle once every element is consumed and the output register is empty. A count of 0 gives done on the cycle after cmd_start, with no pairs.
- R12: An index stream's ready is high only while busy and only when the mode indexes that side. The unused stream is never consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start a command, taken when not busy |
| cmd_mode | input | 2 | Indexing mode |
| cmd_count | input | 16 | Number of elements |
| cmd_src_base | input | 64 | Source start address |
| cmd_dst_base | input | 64 | Destination start address |
| cmd_src_step | input | 32 | Source step in elements, when strided |
| cmd_dst_step | input | 32 | Destination step in elements, when strided |
| cmd_src_esize | input | 16 | Source element size in bytes |
| cmd_dst_esize | input | 16 | Destination element size in bytes |
| cmd_src_bchk | input | 8 | Source check byte |
| cmd_dst_bchk | input | 8 | Destination check byte |
| cmd_bound_err | input | 1 | Out-of-bounds indices may raise errors |
| cmd_allow_dup | input | 1 | Repeated destination indices permitted |
| cmd_reduce | input | 3 | Reduce opcode passed with each pair |
| bound_regs | input | 2048 | 64 bound registers of 32 bits |
| src_idx_valid | input | 1 | Source index valid |
| src_idx_ready | output | 1 | Source index ready |
| src_idx | input | 32 | Source index |
| dst_idx_valid | input | 1 | Destination index valid |
| dst_idx_ready | output | 1 | Destination index ready |
| dst_idx | input | 32 | Destination index |
| out_valid | output | 1 | Address pair valid |
| out_ready | input | 1 | Address pair accepted |
| out_src_addr | output | 64 | Source address |
| out_dst_addr | output | 64 | Destination address |
| out_reduce | output | 3 | Reduce opcode |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete pulse |
| cmd_reject | output | 1 | Command refused pulse |
| err_bound | output | 1 | Bound error pulse |
| err_dup | output | 1 | Repeated destination error pulse |

## Verification
The bench runs the gather, scatter and dual modes with arithmetic index sequences. Each run is compared against addresses computed from the formulas, so a swapped mode, a wrong element size or a step that skips dropped elements shows up as a wrong address. The scatter runs repeat the same indices with the duplicate permission cleared and set, and one run goes past the seen-set depth. These separate dropping from emitting and show where recording stops. The dual-mode runs mix in-range and out-of-range indices with one quiet side, with the error flag on and off, so skipping and error reporting are checked independently. Further runs cover counts of 0, 4096 and 4097, the reserved mode, and output back-pressure.

// File: rtl/iag_pkg.sv
package iag_pkg;

  typedef enum logic [1:0] {
    MODE_GATHER  = 2'd0,
    MODE_SCATTER = 2'd1,
    MODE_DUAL    = 2'd2,
    MODE_RSVD    = 2'd3
  } iag_mode_e;

  typedef enum logic [2:0] {
    RED_NONE = 3'd0,
    RED_ADD  = 3'd1,
    RED_MUL  = 3'd2,
    RED_MAX  = 3'd3,
    RED_MIN  = 3'd4
  } iag_reduce_e;

  // check byte: enable in bit 7, quiet in bit 6, register select in bits 5:0
  typedef struct packed {
    logic       enable;
    logic       quiet;
    logic [5:0] sel;
  } iag_bchk_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } iag_state_e;

endpackage

// File: rtl/iag_side.sv
module iag_side
  import iag_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int IDX_W    = 32,
  parameter int STEP_W   = 32,
  parameter int ESZ_W    = 16,
  parameter int NUM_BREG = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         base_in,
  input  logic [STEP_W-1:0]         step_in,
  input  logic [ESZ_W-1:0]          esize_in,
  input  iag_bchk_t                 bchk_in,
  input  logic                      advance,
  input  logic                      indexed,
  input  logic [IDX_W-1:0]          idx,
  input  logic [NUM_BREG*IDX_W-1:0] bound_regs,
  output logic [ADDR_W-1:0]         addr,
  output logic                      oob,
  output logic                      notify
);

  logic [ADDR_W-1:0] base_q, walk_q, stride, offset;
  logic [ESZ_W-1:0]  esize_q;
  logic [STEP_W-1:0] step_q;
  iag_bchk_t         bchk_q;
  logic [IDX_W-1:0]  bound;

  assign stride = ADDR_W'(step_q) * ADDR_W'(esize_q);
  assign offset = ADDR_W'(idx) * ADDR_W'(esize_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      walk_q  <= '0;
      esize_q <= '0;
      step_q  <= '0;
      bchk_q  <= '0;
    end else if (load) begin
      base_q  <= base_in;
      walk_q  <= base_in;
      esize_q <= esize_in;
      step_q  <= step_in;
      bchk_q  <= bchk_in;
    end else if (advance) begin
      walk_q  <= walk_q + stride;
    end
  end

  always_comb begin
    bound = '0;
    for (int i = 0; i < NUM_BREG; i++)
      if (bchk_q.sel == 6'(i)) bound = bound_regs[i*IDX_W +: IDX_W];
  end

  assign addr   = indexed ? base_q + offset : walk_q;
  assign oob    = indexed && bchk_q.enable && (idx >= bound);
  assign notify = oob && !bchk_q.quiet;

  // R3: a strided side moves by exactly one stride per consumed element
  assert_walk_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && !indexed) |=> (addr == $past(walk_q) + $past(stride)));

endmodule

// File: rtl/iag_seen_set.sv
module iag_seen_set #(
  parameter int IDX_W = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [IDX_W-1:0] key,
  input  logic             insert,
  output logic             hit
);

  localparam int PTR_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] keys [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] fill;
  logic             full;

  assign full = (fill == PTR_W'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign match[g] = vld[g] && (keys[g] == key);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g]  <= 1'b0;
        keys[g] <= '0;
      end else if (clear) begin
        vld[g]  <= 1'b0;
      end else if (insert && !full && fill == PTR_W'(g)) begin
        vld[g]  <= 1'b1;
        keys[g] <= key;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fill <= '0;
    else if (clear)            fill <= '0;
    else if (insert && !full)  fill <= fill + PTR_W'(1);
  end

  assign hit = |match;

  // R9: a freshly emptied set cannot report a repeat
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !hit);

endmodule

// File: rtl/indirect_addr_gen.sv
module indirect_addr_gen
  import iag_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int IDX_W     = 32,
  parameter int STEP_W    = 32,
  parameter int ESZ_W     = 16,
  parameter int CNT_IN_W  = 16,
  parameter int MAX_COUNT = 4096,
  parameter int NUM_BREG  = 64,
  parameter int DUP_DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_start,
  input  logic [1:0]                cmd_mode,
  input  logic [CNT_IN_W-1:0]       cmd_count,
  input  logic [ADDR_W-1:0]         cmd_src_base,
  input  logic [ADDR_W-1:0]         cmd_dst_base,
  input  logic [STEP_W-1:0]         cmd_src_step,
  input  logic [STEP_W-1:0]         cmd_dst_step,
  input  logic [ESZ_W-1:0]          cmd_src_esize,
  input  logic [ESZ_W-1:0]          cmd_dst_esize,
  input  logic [7:0]                cmd_src_bchk,
  input  logic [7:0]                cmd_dst_bchk,
  input  logic                      cmd_bound_err,
  input  logic                      cmd_allow_dup,
  input  logic [2:0]                cmd_reduce,
  input  logic [NUM_BREG*IDX_W-1:0] bound_regs,
  input  logic                      src_idx_valid,
  output logic                      src_idx_ready,
  input  logic [IDX_W-1:0]          src_idx,
  input  logic                      dst_idx_valid,
  output logic                      dst_idx_ready,
  input  logic [IDX_W-1:0]          dst_idx,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [ADDR_W-1:0]         out_src_addr,
  output logic [ADDR_W-1:0]         out_dst_addr,
  output logic [2:0]                out_reduce,
  output logic                      busy,
  output logic                      done,
  output logic                      cmd_reject,
  output logic                      err_bound,
  output logic                      err_dup
);

  localparam int CNT_W = $clog2(MAX_COUNT + 1);

  iag_state_e       state;
  iag_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q, k_q;
  logic [2:0]       reduce_q;
  logic             allow_dup_q, bound_err_q;

  logic accept, bad, launch;
  logic need_src, need_dst, have, oob_any, dup, skip, out_free, take, emit, last;
  logic [ADDR_W-1:0] s_addr, d_addr;
  logic s_oob, d_oob, s_note, d_note, seen_hit;

  assign accept   = cmd_start && (state == ST_IDLE);
  assign bad      = (cmd_mode == MODE_RSVD) || (cmd_count > CNT_IN_W'(MAX_COUNT));
  assign launch   = accept && !bad;

  assign need_src = (mode_q != MODE_SCATTER);
  assign need_dst = (mode_q != MODE_GATHER);
  assign have     = (!need_src || src_idx_valid) && (!need_dst || dst_idx_valid);
  assign oob_any  = s_oob || d_oob;
  assign dup      = need_dst && !allow_dup_q && seen_hit && !oob_any;
  assign skip     = oob_any || dup;
  assign out_free = !out_valid || out_ready;
  assign take     = (state == ST_RUN) && have && (skip || out_free);
  assign emit     = take && !skip;
  assign last     = (k_q == cnt_q - CNT_W'(1));

  assign src_idx_ready = take && need_src;
  assign dst_idx_ready = take && need_dst;

  // one address unit per side; side 0 is the source, side 1 the destination
  iag_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .STEP_W(STEP_W), .ESZ_W(ESZ_W),
             .NUM_BREG(NUM_BREG)) u_src_side (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .base_in(cmd_src_base), .step_in(cmd_src_step), .esize_in(cmd_src_esize),
    .bchk_in(iag_bchk_t'(cmd_src_bchk)), .advance(take), .indexed(need_src),
    .idx(src_idx), .bound_regs(bound_regs),
    .addr(s_addr), .oob(s_oob), .notify(s_note));

  iag_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .STEP_W(STEP_W), .ESZ_W(ESZ_W),
             .NUM_BREG(NUM_BREG)) u_dst_side (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .base_in(cmd_dst_base), .step_in(cmd_dst_step), .esize_in(cmd_dst_esize),
    .bchk_in(iag_bchk_t'(cmd_dst_bchk)), .advance(take), .indexed(need_dst),
    .idx(dst_idx), .bound_regs(bound_regs),
    .addr(d_addr), .oob(d_oob), .notify(d_note));

  iag_seen_set #(.IDX_W(IDX_W), .DEPTH(DUP_DEPTH)) u_seen (
    .clk(clk), .rst_n(rst_n), .clear(launch), .key(dst_idx),
    .insert(emit && need_dst), .hit(seen_hit));

  // command capture and sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode_q      <= MODE_GATHER;
      cnt_q       <= '0;
      k_q         <= '0;
      reduce_q    <= '0;
      allow_dup_q <= 1'b0;
      bound_err_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (launch) begin
          mode_q      <= iag_mode_e'(cmd_mode);
          cnt_q       <= CNT_W'(cmd_count);
          k_q         <= '0;
          reduce_q    <= cmd_reduce;
          allow_dup_q <= cmd_allow_dup;
          bound_err_q <= cmd_bound_err;
          state       <= (cmd_count == '0) ? ST_DRAIN : ST_RUN;
        end
        ST_RUN: if (take) begin
          k_q <= k_q + CNT_W'(1);
          if (last) state <= ST_DRAIN;
        end
        ST_DRAIN: if (!out_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // output holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_src_addr <= '0;
      out_dst_addr <= '0;
      out_reduce   <= '0;
    end else if (emit) begin
      out_valid    <= 1'b1;
      out_src_addr <= s_addr;
      out_dst_addr <= d_addr;
      out_reduce   <= reduce_q;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  // status pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_reject <= 1'b0;
      err_bound  <= 1'b0;
      err_dup    <= 1'b0;
    end else begin
      cmd_reject <= accept && bad;
      err_bound  <= take && bound_err_q && (s_note || d_note);
      err_dup    <= take && dup;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DRAIN) && !out_valid;

  // R10: an offered pair is held until accepted
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src_addr) &&
                                   $stable(out_dst_addr) && $stable(out_reduce)));

  // R4: a refused command leaves the block idle
  assert_reject_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> !busy);

  // R11: done closes the command
  assert_done_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R12: no index is taken outside a command
  assert_ready_in_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx_ready || dst_idx_ready) |-> busy);

  // R9: repeat errors only when repeats are forbidden
  assert_dup_policy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_dup |-> !allow_dup_q);

endmodule

// File: tb/indirect_addr_gen_test.sv
`timescale 1ns/1ps
module indirect_addr_gen_test;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_mode = '0;
  logic [15:0] cmd_count = '0;
  logic [63:0] cmd_src_base = '0, cmd_dst_base = '0;
  logic [31:0] cmd_src_step = '0, cmd_dst_step = '0;
  logic [15:0] cmd_src_esize = '0, cmd_dst_esize = '0;
  logic [7:0]  cmd_src_bchk = '0, cmd_dst_bchk = '0;
  logic        cmd_bound_err = 1'b0, cmd_allow_dup = 1'b0;
  logic [2:0]  cmd_reduce = '0;
  logic [2047:0] bound_regs;
  logic        src_idx_valid = 1'b0, dst_idx_valid = 1'b0;
  logic [31:0] src_idx = '0, dst_idx = '0;
  logic        src_idx_ready, dst_idx_ready;
  logic        out_valid, out_ready = 1'b0;
  logic [63:0] out_src_addr, out_dst_addr;
  logic [2:0]  out_reduce;
  logic        busy, done, cmd_reject, err_bound, err_dup;

  indirect_addr_gen uut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [31:0] sq[$], dq[$];
  logic [63:0] exp_s[$], exp_d[$];
  int exp_eb, exp_ed;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bnd(input logic [5:0] sel);
    return 32'(10) + 32'(sel);
  endfunction

  // expected results from the requirement formulas
  task automatic model();
    logic [31:0] seen[$];
    bit s_ix, d_ix, s_o, d_o, rep;
    exp_s.delete(); exp_d.delete(); exp_eb = 0; exp_ed = 0;
    s_ix = (cmd_mode != 2'd1);
    d_ix = (cmd_mode != 2'd0);
    for (int k = 0; k < int'(cmd_count); k++) begin
      s_o = s_ix && cmd_src_bchk[7] && (sq[k] >= bnd(cmd_src_bchk[5:0]));
      d_o = d_ix && cmd_dst_bchk[7] && (dq[k] >= bnd(cmd_dst_bchk[5:0]));
      if (cmd_bound_err && ((s_o && !cmd_src_bchk[6]) || (d_o && !cmd_dst_bchk[6])))
        exp_eb++;
      rep = 1'b0;
      if (!s_o && !d_o && d_ix && !cmd_allow_dup)
        foreach (seen[j]) if (seen[j] == dq[k]) rep = 1'b1;
      if (rep) exp_ed++;
      if (!s_o && !d_o && !rep) begin
        exp_s.push_back(s_ix ? cmd_src_base + 64'(sq[k]) * 64'(cmd_src_esize)
                             : cmd_src_base + 64'(k) * 64'(cmd_src_step) * 64'(cmd_src_esize));
        exp_d.push_back(d_ix ? cmd_dst_base + 64'(dq[k]) * 64'(cmd_dst_esize)
                             : cmd_dst_base + 64'(k) * 64'(cmd_dst_step) * 64'(cmd_dst_esize));
        if (d_ix && seen.size() < DEPTH) seen.push_back(dq[k]);
      end
    end
  endtask

  task automatic run(input bit bp, input bit want_reject, input string req);
    int sp = 0, dp = 0, oc = 0, eb = 0, ed = 0, cyc = 0;
    bit fin = 0, rej = 0, dn = 0, held = 0;
    logic [63:0] hs = '0, hd = '0;
    if (!want_reject) model();
    @(negedge clk);
    cmd_start = 1'b1;
    while (!fin && cyc < 10000) begin
      @(negedge clk);
      cmd_start = 1'b0;
      cyc++;
      src_idx_valid = (sp < sq.size());
      src_idx = src_idx_valid ? sq[sp] : 32'hDEAD_BEEF;
      dst_idx_valid = (dp < dq.size());
      dst_idx = dst_idx_valid ? dq[dp] : 32'hDEAD_BEEF;
      out_ready = bp ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (held) begin
        chk(out_valid && out_src_addr == hs && out_dst_addr == hd, "R10",
            "pair held under back-pressure", out_src_addr, hs);
        held = 0;
      end
      if (out_valid && !out_ready) begin
        held = 1; hs = out_src_addr; hd = out_dst_addr;
      end
      if (src_idx_valid && src_idx_ready) sp++;
      if (dst_idx_valid && dst_idx_ready) dp++;
      if (out_valid && out_ready) begin
        if (oc < exp_s.size()) begin
          chk(out_src_addr == exp_s[oc], req, "source address", out_src_addr, exp_s[oc]);
          chk(out_dst_addr == exp_d[oc], req, "destination address", out_dst_addr, exp_d[oc]);
          chk(out_reduce == cmd_reduce, "R8", "reduce opcode", 64'(out_reduce), 64'(cmd_reduce));
        end
        oc++;
      end
      if (err_bound) eb++;
      if (err_dup) ed++;
      if (cmd_reject) begin rej = 1; fin = 1; end
      if (done) begin dn = 1; fin = 1; end
    end
    src_idx_valid = 1'b0; dst_idx_valid = 1'b0;
    if (want_reject) begin
      chk(rej && !dn, "R4", "reject pulse without done", 64'(rej), 64'd1);
      chk(oc == 0 && sp == 0 && dp == 0, "R4", "nothing produced or consumed",
          64'(oc + sp + dp), 64'd0);
      @(negedge clk);
      chk(!busy && !cmd_reject && !done, "R4", "idle after reject", 64'(busy), 64'd0);
    end else begin
      chk(dn && !rej, "R11", "done pulse", 64'(dn), 64'd1);
      chk(oc == exp_s.size(), req, "pair count", 64'(oc), 64'(exp_s.size()));
      chk(eb == exp_eb, "R7", "bound error pulses", 64'(eb), 64'(exp_eb));
      chk(ed == exp_ed, "R9", "repeat error pulses", 64'(ed), 64'(exp_ed));
      chk(sp == ((cmd_mode != 2'd1) ? int'(cmd_count) : 0), "R12", "source indices taken",
          64'(sp), 64'((cmd_mode != 2'd1) ? int'(cmd_count) : 0));
      chk(dp == ((cmd_mode != 2'd0) ? int'(cmd_count) : 0), "R12", "destination indices taken",
          64'(dp), 64'((cmd_mode != 2'd0) ? int'(cmd_count) : 0));
      @(negedge clk);
      chk(!busy && !done, "R11", "single done pulse then idle", 64'(done), 64'd0);
    end
  endtask

  task automatic setup(input logic [1:0] m, input int n, input logic [2:0] red);
    cmd_mode = m; cmd_count = 16'(n); cmd_reduce = red;
    cmd_src_base = 64'h0000_0000_1000_0000; cmd_dst_base = 64'h0000_8000_0000_0000;
    cmd_src_step = 32'd3; cmd_dst_step = 32'd2;
    cmd_src_esize = 16'd4; cmd_dst_esize = 16'd8;
    cmd_src_bchk = 8'h00; cmd_dst_bchk = 8'h00;
    cmd_bound_err = 1'b0; cmd_allow_dup = 1'b0;
    sq.delete(); dq.delete();
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) bound_regs[i*32 +: 32] = 32'(10 + i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !busy && !done && !src_idx_ready && !dst_idx_ready && !err_bound,
        "R11", "reset state", 64'(out_valid), 64'd0);

    // R1 R2 R3: gather, unused destination stream offered but never taken (R12)
    setup(2'd0, 10, 3'd1);
    for (int k = 0; k < 10; k++) sq.push_back(32'(k * 3 + 1));
    for (int k = 0; k < 5; k++) dq.push_back(32'(k));
    run(1'b1, 1'b0, "R1 R2 R3 gather");

    // R9: scatter with repeats forbidden
    setup(2'd1, 8, 3'd1);
    cmd_src_esize = 16'd2; cmd_dst_esize = 16'd16; cmd_src_step = 32'd1;
    dq = '{5, 9, 5, 12, 9, 3, 5, 7};
    run(1'b0, 1'b0, "R9 scatter no repeat");

    // R9: scatter with repeats allowed
    setup(2'd1, 8, 3'd3);
    cmd_allow_dup = 1'b1;
    dq = '{5, 9, 5, 12, 9, 3, 5, 7};
    run(1'b1, 1'b0, "R9 scatter repeat allowed");

    // R9: seen-set depth limit
    setup(2'd1, 20, 3'd0);
    for (int k = 0; k < 17; k++) dq.push_back(32'(k));
    dq.push_back(32'd0); dq.push_back(32'd16); dq.push_back(32'd3);
    run(1'b0, 1'b0, "R9 seen-set depth");

    // R5 R6 R7: dual mode, source bound reg 5 (=15) loud, destination reg 0 (=10) quiet
    setup(2'd2, 12, 3'd4);
    cmd_src_bchk = 8'h85; cmd_dst_bchk = 8'hC0; cmd_bound_err = 1'b1; cmd_allow_dup = 1'b1;
    for (int k = 0; k < 12; k++) begin sq.push_back(32'(k * 2)); dq.push_back(32'(k + 3)); end
    run(1'b1, 1'b0, "R5 R6 R7 dual bounds");

    // R7: same stimulus, error reporting off
    setup(2'd2, 12, 3'd2);
    cmd_src_bchk = 8'h85; cmd_dst_bchk = 8'hC0; cmd_bound_err = 1'b0; cmd_allow_dup = 1'b1;
    for (int k = 0; k < 12; k++) begin sq.push_back(32'(k * 2)); dq.push_back(32'(k + 3)); end
    run(1'b0, 1'b0, "R6 R7 bounds quiet");

    // R5: check enable clear lets large indices through; dual mode with huge values
    setup(2'd2, 6, 3'd1);
    cmd_src_bchk = 8'h05; cmd_allow_dup = 1'b1;
    for (int k = 0; k < 6; k++) begin
      sq.push_back(32'hFFFF_FFF0 + 32'(k)); dq.push_back(32'h8000_0000 + 32'(k));
    end
    run(1'b0, 1'b0, "R2 R5 unchecked wide");

    // R4: too long, and reserved mode
    setup(2'd0, 4097, 3'd0);
    run(1'b0, 1'b1, "R4");
    setup(2'd3, 4, 3'd0);
    sq = '{1, 2, 3, 4}; dq = '{1, 2, 3, 4};
    run(1'b0, 1'b1, "R1 R4 reserved");

    // R11: empty command
    setup(2'd0, 0, 3'd0);
    run(1'b0, 1'b0, "R11 empty");

    // R4 R3: largest legal command
    setup(2'd0, 4096, 3'd1);
    for (int k = 0; k < 4096; k++) sq.push_back(32'(k ^ 7));
    run(1'b0, 1'b0, "R3 R4 full count");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule